// File: doc/BRIEF.md
# Fixed-Length Packet Transmit Framer

This block turns a transmit byte FIFO into a serial radio packet with a fixed layout. After an accepted start pulse it sends, most significant bit first and one bit for each bit-clock enable, a run of 0xAA preamble bytes, a start pattern of one to four bytes that acts as the network address, an optional node address byte, the payload data bytes read from the FIFO, and an optional two-byte CRC-16-CCITT.

The host sets a 2-bit operating mode, a packet-format select, a 7-bit payload length, flags for the address byte and the CRC, and the preamble and start-pattern contents. These settings are captured when a packet starts. The FIFO shows its head byte on `fifo_data` (show-ahead), and `fifo_rd` consumes it. The block reports progress with `busy`, a one-cycle `done` pulse and a one-cycle `underrun` pulse.

Top module: `pkt_tx_framer`

## Requirements
- R1: The packet goes out in this order: `pre_cnt` bytes of 0xAA, then `sync_last`+1 start-pattern bytes taken from `sync_word` starting at bits [31:24] and moving down, then `node_addr` if `addr_en`=1, then the data bytes, then the CRC if `crc_en`=1. Every byte is sent MSB first, and one bit is consumed on each clock where `busy`=1 and `bit_en`=1.
- R2: A start is accepted only when `op_mode` is 2'b10 or 2'b11. With 2'b00 or 2'b01 a start pulse is ignored and `busy` stays 0.
- R3: A start is refused when `fmt_var`=1, when `pay_len`=0, or when `pay_len` is greater than FIFO_DEPTH (default 64).
- R4: `pay_len` counts the node address byte when `addr_en`=1, so exactly `pay_len`-`addr_en` data bytes are read from the FIFO. With `pay_len`=1 and `addr_en`=1, no data bytes are read.
- R5: The CRC uses polynomial 0x1021 with a seed of 0xFFFF. It covers the address byte and the data bytes only, and it is sent high byte first. No CRC bytes are sent when `crc_en`=0.
- R6: `busy` is 1 in the cycle after an accepted start. It falls at the clock edge that consumes the final bit. `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R7: If the FIFO is empty when a data byte is due, the block issues no read, pulses `underrun` for one cycle, drops `busy` and gives no `done`. All bytes before that data byte have already been sent in full.
- R8: `fifo_rd` is high for one cycle for each data byte, and only in a cycle where `busy`=1, `bit_en`=1 and the FIFO is not empty. The byte on `fifo_data` in that cycle is the byte that gets sent.
- R9: Changes to any configuration input while a packet is in flight, `op_mode` included, have no effect on that packet.
- R10: After reset, `busy`, `done`, `underrun`, `fifo_rd` and `tx_bit` are all 0.
- R11: A start pulse while `busy`=1 is ignored, and the packet in flight continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 2 | Operating mode; 2'b1x enables packet handling |
| fmt_var | input | 1 | Packet-format select; 1 selects variable length (refused) |
| pay_len | input | 7 | Payload length in bytes, address byte included |
| addr_en | input | 1 | Send the node address byte |
| crc_en | input | 1 | Append the two-byte CRC |
| node_addr | input | 8 | Node address byte |
| pre_cnt | input | 4 | Number of preamble bytes (0 to 15) |
| sync_last | input | 2 | Start-pattern length minus one |
| sync_word | input | 32 | Start-pattern bytes, first byte in bits [31:24] |
| start | input | 1 | Begin a packet |
| bit_en | input | 1 | Bit-clock enable; one bit per high cycle |
| fifo_data | input | 8 | Head byte of the transmit FIFO (show-ahead) |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| fifo_rd | output | 1 | Consume the FIFO head byte |
| tx_bit | output | 1 | Serial data out (0 when idle) |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse after a completed packet |
| underrun | output | 1 | One-cycle pulse when a packet is aborted for an empty FIFO |

## Verification
The bench goes after the field boundaries. A packet with only the address byte and no data must go straight from the address to the end without a FIFO read; a design that ignores the length rule would read one byte too many and shift the CRC. A zero-length preamble and a single-byte start pattern check that the sequencer can skip or shorten a field; an off-by-one here would send an extra 0xAA or a stale pattern byte. Underruns at the first data byte and in the middle of the payload check that the abort happens before any read and that no `done` follows. Rewriting every setting in mid-packet and sending a second start catch a design that reads its configuration live or restarts while busy.

// File: rtl/ptf_pkg.sv
`timescale 1ns/1ps
package ptf_pkg;

    localparam int LEN_W      = 7;
    localparam int PRE_W      = 4;
    localparam int SYNC_IDX_W = 2;
    localparam int SYNC_BYTES = 1 << SYNC_IDX_W;
    localparam int SYNC_W     = 8 * SYNC_BYTES;

    localparam logic [7:0]  PREAMBLE_BYTE = 8'hAA;
    localparam logic [15:0] CRC_POLY      = 16'h1021;
    localparam logic [15:0] CRC_SEED      = 16'hFFFF;

    // Ordering matters: fields advance only upward within a packet.
    typedef enum logic [2:0] {
        F_IDLE = 3'd0,
        F_PRE  = 3'd1,
        F_SYNC = 3'd2,
        F_ADDR = 3'd3,
        F_DATA = 3'd4,
        F_CRCH = 3'd5,
        F_CRCL = 3'd6
    } field_e;

    typedef struct packed {
        logic [PRE_W-1:0]      pre_n;
        logic [SYNC_IDX_W-1:0] sync_last;
        logic                  addr_on;
        logic                  crc_on;
        logic [LEN_W-1:0]      data_n;
        logic [SYNC_W-1:0]     sync_word;
        logic [7:0]            node;
    } cfg_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] sync_pick(input logic [SYNC_W-1:0] w,
                                             input logic [SYNC_IDX_W-1:0] idx);
        return w[(SYNC_W - 1 - 8 * int'(idx)) -: 8];
    endfunction

endpackage

// File: rtl/ptf_seq.sv
`timescale 1ns/1ps
module ptf_seq
    import ptf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  field_e                first_fld,
    input  logic                  adv,
    input  logic                  abort,
    input  logic [PRE_W-1:0]      pre_n,
    input  logic [SYNC_IDX_W-1:0] sync_last,
    input  logic                  addr_on,
    input  logic                  crc_on,
    input  logic [LEN_W-1:0]      data_n,
    output field_e                field_q,
    output field_e                nxt_fld,
    output logic [SYNC_IDX_W-1:0] nxt_sidx,
    output logic                  done,
    output logic                  underrun
);

    localparam int CW = LEN_W + 1;

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] nxt_cnt;
    logic [CW-1:0]    cnt_inc;
    logic [CW-1:0]    pre_lim;
    logic [CW-1:0]    data_lim;
    field_e           tail_f;
    field_e           body_f;

    always_comb begin
        cnt_inc  = {1'b0, cnt_q} + CW'(1);
        pre_lim  = CW'(pre_n);
        data_lim = {1'b0, data_n};
        tail_f   = crc_on ? F_CRCH : F_IDLE;
        body_f   = (data_n != '0) ? F_DATA : tail_f;
        nxt_fld  = F_IDLE;
        nxt_cnt  = '0;
        case (field_q)
            F_PRE: begin
                if (cnt_inc < pre_lim) begin
                    nxt_fld = F_PRE;
                    nxt_cnt = cnt_inc[LEN_W-1:0];
                end else begin
                    nxt_fld = F_SYNC;
                end
            end
            F_SYNC: begin
                if (cnt_q[SYNC_IDX_W-1:0] != sync_last) begin
                    nxt_fld = F_SYNC;
                    nxt_cnt = cnt_inc[LEN_W-1:0];
                end else begin
                    nxt_fld = addr_on ? F_ADDR : body_f;
                end
            end
            F_ADDR: nxt_fld = body_f;
            F_DATA: begin
                if (cnt_inc < data_lim) begin
                    nxt_fld = F_DATA;
                    nxt_cnt = cnt_inc[LEN_W-1:0];
                end else begin
                    nxt_fld = tail_f;
                end
            end
            F_CRCH:  nxt_fld = F_CRCL;
            default: nxt_fld = F_IDLE;
        endcase
        nxt_sidx = nxt_cnt[SYNC_IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q  <= F_IDLE;
            cnt_q    <= '0;
            done     <= 1'b0;
            underrun <= 1'b0;
        end else begin
            done     <= 1'b0;
            underrun <= 1'b0;
            if (go) begin
                field_q <= first_fld;
                cnt_q   <= '0;
            end else if (adv) begin
                if (abort) begin
                    field_q  <= F_IDLE;
                    cnt_q    <= '0;
                    underrun <= 1'b1;
                end else begin
                    field_q <= nxt_fld;
                    cnt_q   <= nxt_cnt;
                    done    <= (nxt_fld == F_IDLE);
                end
            end
        end
    end

    // R1: within one packet the field never moves backwards
    a_r1_field_forward: assert property (@(posedge clk) disable iff (rst)
        (field_q != F_IDLE && $past(field_q) != F_IDLE) |-> (field_q >= $past(field_q)));

    // R6: done is a single-cycle pulse that follows activity
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(field_q) != F_IDLE));

    // R7: an underrun leaves the framer idle and never signals completion
    a_r7_underrun_idle: assert property (@(posedge clk) disable iff (rst)
        underrun |-> (field_q == F_IDLE && !done));

endmodule

// File: rtl/ptf_crc.sv
`timescale 1ns/1ps
module ptf_crc
    import ptf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_SEED;
        end else if (init) begin
            crc_q <= CRC_SEED;
        end else if (upd) begin
            crc_q <= crc_step(crc_q, din);
        end
    end

    // R5: every packet starts its checksum from the seed
    a_r5_seed_on_start: assert property (@(posedge clk) disable iff (rst)
        init |=> (crc_q == CRC_SEED));

endmodule

// File: rtl/ptf_ser.sv
`timescale 1ns/1ps
module ptf_ser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb,
    output logic         at_last
);

    localparam int CW = $clog2(W);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] bc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            bc_q <= '0;
        end else if (load) begin
            sh_q <= din;
            bc_q <= '0;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
            bc_q <= bc_q + CW'(1);
        end
    end

    assign msb     = sh_q[W-1];
    assign at_last = (bc_q == CW'(W - 1));

    // R1: a freshly loaded byte presents its most significant bit first
    a_r1_msb_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (msb == $past(din[W-1])));

endmodule

// File: rtl/pkt_tx_framer.sv
`timescale 1ns/1ps
module pkt_tx_framer
    import ptf_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            op_mode,
    input  logic                  fmt_var,
    input  logic [LEN_W-1:0]      pay_len,
    input  logic                  addr_en,
    input  logic                  crc_en,
    input  logic [7:0]            node_addr,
    input  logic [PRE_W-1:0]      pre_cnt,
    input  logic [SYNC_IDX_W-1:0] sync_last,
    input  logic [SYNC_W-1:0]     sync_word,
    input  logic                  start,
    input  logic                  bit_en,
    input  logic [7:0]            fifo_data,
    input  logic                  fifo_empty,
    output logic                  fifo_rd,
    output logic                  tx_bit,
    output logic                  busy,
    output logic                  done,
    output logic                  underrun
);

    localparam logic [LEN_W:0] DEPTH_L = (LEN_W + 1)'(FIFO_DEPTH);

    cfg_t                  cfg_in;
    cfg_t                  cfg_q;
    field_e                field_q;
    field_e                nxt_fld;
    field_e                first_fld;
    logic [SYNC_IDX_W-1:0] nxt_sidx;
    logic [15:0]           crc_q;
    logic                  pkt_mode;
    logic                  len_ok;
    logic                  accept;
    logic                  adv;
    logic                  need_data;
    logic                  abort;
    logic                  load;
    logic                  crc_upd;
    logic                  ser_msb;
    logic                  ser_last;
    logic [7:0]            load_byte;

    // ---- start qualification and configuration capture ----
    assign pkt_mode = (op_mode == 2'b10) || (op_mode == 2'b11);
    assign len_ok   = (pay_len != '0) && ({1'b0, pay_len} <= DEPTH_L);
    assign busy     = (field_q != F_IDLE);
    assign accept   = start && !busy && pkt_mode && !fmt_var && len_ok;

    always_comb begin
        cfg_in.pre_n     = pre_cnt;
        cfg_in.sync_last = sync_last;
        cfg_in.addr_on   = addr_en;
        cfg_in.crc_on    = crc_en;
        cfg_in.data_n    = pay_len - LEN_W'(addr_en);
        cfg_in.sync_word = sync_word;
        cfg_in.node      = node_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q <= cfg_in;
        end
    end

    assign first_fld = (pre_cnt != '0) ? F_PRE : F_SYNC;

    // R2: outside packet mode the framer never leaves idle
    a_r2_idle_without_mode: assert property (@(posedge clk) disable iff (rst)
        (!busy && !pkt_mode) |=> !busy);
    // R3: the variable-length format is refused
    a_r3_variable_refused: assert property (@(posedge clk) disable iff (rst)
        (!busy && fmt_var) |=> !busy);

    // ---- byte boundary control ----
    assign adv       = busy && bit_en && ser_last;
    assign need_data = (nxt_fld == F_DATA);
    assign abort     = adv && need_data && fifo_empty;
    assign fifo_rd   = adv && need_data && !fifo_empty;
    assign load      = accept || (adv && !abort && (nxt_fld != F_IDLE));
    assign crc_upd   = adv && !abort && ((nxt_fld == F_ADDR) || need_data);

    // R8: a read only happens on a bit boundary and never on an empty FIFO
    a_r8_read_needs_data: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);
    a_r8_read_on_bit: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (busy && bit_en));

    always_comb begin
        if (accept) begin
            load_byte = (pre_cnt != '0) ? PREAMBLE_BYTE : sync_pick(sync_word, '0);
        end else begin
            case (nxt_fld)
                F_PRE:   load_byte = PREAMBLE_BYTE;
                F_SYNC:  load_byte = sync_pick(cfg_q.sync_word, nxt_sidx);
                F_ADDR:  load_byte = cfg_q.node;
                F_DATA:  load_byte = fifo_data;
                F_CRCH:  load_byte = crc_q[15:8];
                F_CRCL:  load_byte = crc_q[7:0];
                default: load_byte = 8'h00;
            endcase
        end
    end

    // ---- submodules ----
    ptf_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (accept),
        .first_fld (first_fld),
        .adv       (adv),
        .abort     (abort),
        .pre_n     (cfg_q.pre_n),
        .sync_last (cfg_q.sync_last),
        .addr_on   (cfg_q.addr_on),
        .crc_on    (cfg_q.crc_on),
        .data_n    (cfg_q.data_n),
        .field_q   (field_q),
        .nxt_fld   (nxt_fld),
        .nxt_sidx  (nxt_sidx),
        .done      (done),
        .underrun  (underrun)
    );

    ptf_crc u_crc (
        .clk   (clk),
        .rst   (rst),
        .init  (accept),
        .upd   (crc_upd),
        .din   (load_byte),
        .crc_q (crc_q)
    );

    ptf_ser #(.W(8)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .din     (load_byte),
        .shift   (busy && bit_en),
        .msb     (ser_msb),
        .at_last (ser_last)
    );

    assign tx_bit = busy && ser_msb;

endmodule

// File: tb/sim_pkt_tx_framer.sv
`timescale 1ns/1ps
module sim_pkt_tx_framer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_mode = 2'b00;
    logic        fmt_var = 1'b0;
    logic [6:0]  pay_len = 7'd0;
    logic        addr_en = 1'b0;
    logic        crc_en = 1'b0;
    logic [7:0]  node_addr = 8'h00;
    logic [3:0]  pre_cnt = 4'd0;
    logic [1:0]  sync_last = 2'd0;
    logic [31:0] sync_word = 32'h0;
    logic        start = 1'b0;
    logic        bit_en = 1'b0;
    logic [7:0]  fifo_data;
    logic        fifo_empty;
    logic        fifo_rd;
    logic        tx_bit;
    logic        busy;
    logic        done;
    logic        underrun;

    int checks = 0;
    int failures = 0;
    int gcyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pkt_tx_framer #(.FIFO_DEPTH(64)) u0 (
        .clk(clk), .rst(rst), .op_mode(op_mode), .fmt_var(fmt_var), .pay_len(pay_len),
        .addr_en(addr_en), .crc_en(crc_en), .node_addr(node_addr), .pre_cnt(pre_cnt),
        .sync_last(sync_last), .sync_word(sync_word), .start(start), .bit_en(bit_en),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .tx_bit(tx_bit), .busy(busy), .done(done), .underrun(underrun)
    );

    // show-ahead FIFO model
    logic [7:0] fmem [0:127];
    int rd_total = 0;
    int wr_lim = 0;
    always @(posedge clk) if (fifo_rd) rd_total <= rd_total + 1;
    assign fifo_data  = fmem[rd_total[6:0]];
    assign fifo_empty = (rd_total >= wr_lim);

    always @(posedge clk) begin
        gcyc <= gcyc + 1;
        if (gcyc > 150000 && !finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", gcyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  pre;
        logic [1:0]  sl;
        logic        ae;
        logic        ce;
        logic [6:0]  len;
        logic [1:0]  stride;
        logic [7:0]  node;
        logic [31:0] sw;
        logic [7:0]  seed;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{2'b10, 4'd3,  2'd1, 1'b1, 1'b1, 7'd5,  2'd1, 8'h5C, 32'hD391_0000, 8'd1},
        '{2'b11, 4'd2,  2'd3, 1'b0, 1'b1, 7'd8,  2'd2, 8'h00, 32'h2DD4_7E81, 8'd2},
        '{2'b10, 4'd0,  2'd0, 1'b0, 1'b0, 7'd1,  2'd1, 8'h00, 32'hC300_0000, 8'd3},
        '{2'b11, 4'd1,  2'd2, 1'b1, 1'b0, 7'd1,  2'd3, 8'hA7, 32'h1234_5600, 8'd4},
        '{2'b10, 4'd4,  2'd3, 1'b1, 1'b1, 7'd64, 2'd1, 8'h3E, 32'hF0E1_D2C3, 8'd5},
        '{2'b11, 4'd15, 2'd1, 1'b0, 1'b1, 7'd2,  2'd2, 8'h00, 32'h8001_0000, 8'd6}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input logic [7:0] s, input int i);
        int t;
        t = int'(s) * 37 + i * 13 + 5;
        return t[7:0];
    endfunction

    // bitwise CCITT update, MSB first
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic fb;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            fb = r[15] ^ d[b];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    logic cap [0:1023];

    task automatic run_pkt(input vec_t v, input int fill, input bit poke,
                           input bit restart, input string tag);
        logic [7:0] eb [0:127];
        int nexp, data_n, sent_data, base, ncap, done_hits, under_hits, rd_bad;
        int cyc, post, mism, first_bad, stride;
        bit under_exp;
        logic [15:0] c;
        data_n    = int'(v.len) - int'(v.ae);
        under_exp = (fill < data_n);
        sent_data = under_exp ? fill : data_n;
        stride    = (v.stride == 0) ? 1 : int'(v.stride);
        base = rd_total;
        for (int i = 0; i < fill; i++) fmem[(base + i) % 128] = dbyte(v.seed, i);
        wr_lim = base + fill;

        nexp = 0;
        c = 16'hFFFF;
        for (int i = 0; i < int'(v.pre); i++) begin eb[nexp] = 8'hAA; nexp++; end
        for (int k = 0; k <= int'(v.sl); k++) begin
            eb[nexp] = v.sw[31 - 8 * k -: 8]; nexp++;
        end
        if (v.ae) begin eb[nexp] = v.node; nexp++; c = ref_crc(c, v.node); end
        for (int i = 0; i < sent_data; i++) begin
            eb[nexp] = dbyte(v.seed, i); c = ref_crc(c, eb[nexp]); nexp++;
        end
        if (!under_exp && v.ce) begin
            eb[nexp] = c[15:8]; nexp++;
            eb[nexp] = c[7:0];  nexp++;
        end

        @(negedge clk);
        op_mode = v.op; fmt_var = 1'b0; pay_len = v.len; addr_en = v.ae; crc_en = v.ce;
        node_addr = v.node; pre_cnt = v.pre; sync_last = v.sl; sync_word = v.sw;
        start = 1'b1; bit_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(busy == 1'b1, "R6", {tag, " busy after start"}, int'(busy), 1);

        ncap = 0; done_hits = 0; under_hits = 0; rd_bad = 0; cyc = 0; post = 0;
        while (post < 3 && cyc < 8000) begin
            if (cyc != 0) begin
                @(negedge clk);
            end else begin
                #0;
            end
            bit_en = ((cyc % stride) == 0);
            start  = (restart && cyc == 20);
            if (poke && cyc == 10) begin
                op_mode = 2'b01; pre_cnt = 4'd9; addr_en = ~addr_en; crc_en = ~crc_en;
                pay_len = 7'd3; sync_word = ~sync_word; node_addr = ~node_addr; sync_last = 2'd0;
            end
            #1;
            if (busy && bit_en && ncap < 1024) begin cap[ncap] = tx_bit; ncap++; end
            if (fifo_rd && !(busy && bit_en)) rd_bad++;
            if (done) done_hits++;
            if (underrun) under_hits++;
            if (done_hits != 0 || under_hits != 0) post++;
            cyc++;
        end
        start = 1'b0;
        bit_en = 1'b0;

        mism = 0; first_bad = -1;
        for (int j = 0; j < ncap && j < nexp * 8; j++) begin
            if (cap[j] !== eb[j / 8][7 - (j % 8)]) begin
                mism++;
                if (first_bad < 0) first_bad = j;
            end
        end
        chk(ncap == nexp * 8, "R1", {tag, " bit count"}, ncap, nexp * 8);
        chk(mism == 0, "R1/R5", {tag, " first wrong bit index"}, first_bad, -1);
        chk(rd_total - base == sent_data, "R4", {tag, " FIFO reads"}, rd_total - base, sent_data);
        chk(done_hits == (under_exp ? 0 : 1), "R6", {tag, " done pulse cycles"},
            done_hits, under_exp ? 0 : 1);
        chk(under_hits == (under_exp ? 1 : 0), "R7", {tag, " underrun pulse cycles"},
            under_hits, under_exp ? 1 : 0);
        chk(rd_bad == 0, "R8", {tag, " reads off a bit boundary"}, rd_bad, 0);
        chk(busy == 1'b0, "R6", {tag, " busy after end"}, int'(busy), 0);
    endtask

    task automatic try_refused(input logic [1:0] op, input bit fv, input logic [6:0] len,
                               input string req, input string tag);
        int busy_seen, rd_seen, ev_seen;
        for (int i = 0; i < 8; i++) fmem[(rd_total + i) % 128] = 8'h11;
        wr_lim = rd_total + 8;
        @(negedge clk);
        op_mode = op; fmt_var = fv; pay_len = len; addr_en = 1'b0; crc_en = 1'b1;
        pre_cnt = 4'd1; sync_last = 2'd0; sync_word = 32'hAB00_0000; start = 1'b1; bit_en = 1'b1;
        busy_seen = 0; rd_seen = 0; ev_seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            start = 1'b0;
            #1;
            if (busy) busy_seen++;
            if (fifo_rd) rd_seen++;
            if (done || underrun) ev_seen++;
        end
        bit_en = 1'b0; fmt_var = 1'b0;
        chk(busy_seen == 0 && rd_seen == 0 && ev_seen == 0, req, {tag, " start refused"},
            busy_seen + rd_seen + ev_seen, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) fmem[i] = 8'h00;
        repeat (4) @(negedge clk);
        #1;
        chk(busy == 0 && done == 0 && underrun == 0 && fifo_rd == 0 && tx_bit == 0,
            "R10", "outputs in reset", int'({busy, done, underrun, fifo_rd, tx_bit}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(busy == 0 && done == 0 && underrun == 0 && fifo_rd == 0 && tx_bit == 0,
            "R10", "outputs after reset", int'({busy, done, underrun, fifo_rd, tx_bit}), 0);

        // table walk: R1 R4 R5 R6 R8 under several layouts and bit rates
        for (int i = 0; i < NVEC; i++) begin
            run_pkt(VECS[i], int'(VECS[i].len) - int'(VECS[i].ae), 1'b0, 1'b0,
                    $sformatf("vec%0d", i));
        end

        // R2: non-packet modes ignore start
        try_refused(2'b00, 1'b0, 7'd4, "R2", "mode00");
        try_refused(2'b01, 1'b0, 7'd4, "R2", "mode01");
        // R3: variable format, zero length, over-depth length
        try_refused(2'b10, 1'b1, 7'd4, "R3", "fmt_var");
        try_refused(2'b11, 1'b0, 7'd0, "R3", "len0");
        try_refused(2'b10, 1'b0, 7'd65, "R3", "len65");

        // R7: underrun mid-payload and at the first data byte
        run_pkt(VECS[1], 3, 1'b0, 1'b0, "R7 mid underrun");
        run_pkt(VECS[0], 0, 1'b0, 1'b0, "R7 first underrun");
        // R9: configuration rewritten mid-packet
        run_pkt(VECS[0], 4, 1'b1, 1'b0, "R9 poke");
        // R11: second start while busy
        run_pkt(VECS[4], 63, 1'b0, 1'b1, "R11 restart");
        // R2 with mode 11 after a poke left op_mode at 01
        run_pkt(VECS[5], 2, 1'b0, 1'b0, "R2 mode11");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule